// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This block is a 16-bit up-counter that a host sees as two byte registers, low and high. Each byte can be read at any time and written on its own. The count input is one of two sources. In timer mode it is an instruction-cycle enable pulse. In counter mode it is the rising edges of an external clock pin. The chosen input passes through a divide-by-1, 2, 4 or 8 prescaler before it reaches the counter. The prescaler is hidden from the host, and any host write to a count byte returns it to zero.

Counting can be qualified by a gate. The gate source is either a synchronized gate pin or an on-chip comparator output, and an invert control picks which level of the gate lets counting through. External edges can be taken through an extra alignment stage, or that stage can be skipped to cut one cycle of latency. When the count wraps from FFFFh to 0000h, a sticky overflow flag is set. An interrupt request is raised when that flag and three separate enables are all set. The whole block runs on one system clock.

Top module: `gated_timer16`

## Requirements
- R1: After a synchronous active-low reset, both count bytes read 0, the overflow flag is 0 and the interrupt request is 0.
- R2: A write with byte select 0 loads the low byte and a write with byte select 1 loads the high byte. The other byte is unchanged. When a write and an increment fall in the same cycle, the written value is kept and the increment is lost.
- R3: With the external source deselected (src_ext=0), every cycle with tick_in high counts as one input event. The prescale select value p (0..3) makes the counter advance once per 2^p events.
- R4: A host write to either count byte clears the hidden prescale counter. The next counter step then needs a full 2^p fresh events.
- R5: With src_ext=1, each rising edge of ext_clk is one input event. After ext_clk is driven high just before a clock edge, bypass mode (no_sync=1) increments the counter on the third clock edge. Aligned mode (no_sync=0) increments it one edge later, on the fourth.
- R6: With gate_en=1, events count only while the gate is active. gate_sel=1 selects cmp_in, which is used directly. gate_sel=0 selects gate_pin through a two-flop synchronizer. The gate is active when the source level XOR gate_inv is 1. With gate_en=0 the gate is ignored.
- R7: While run_en is 0, the count and the prescale counter both hold their values. Counting resumes from the same prescaler phase when run_en returns to 1.
- R8: The wrap from FFFFh to 0000h sets ovf_flag on the same clock edge. The flag stays set until flag_clr is pulsed. If a clear and a new wrap fall in the same cycle, the flag stays set.
- R9: irq is 1 exactly when ovf_flag, ie_local, ie_periph and ie_global are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for a count byte |
| wr_sel | input | 1 | Byte select for the write: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Byte value to write |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| run_en | input | 1 | 1 lets the timer run, 0 holds it |
| src_ext | input | 1 | 0 = count tick_in, 1 = count ext_clk rising edges |
| no_sync | input | 1 | 1 = skip the extra alignment stage on external edges |
| psc_sel | input | 2 | Prescale select: divide by 2^psc_sel |
| gate_en | input | 1 | 1 = counting is qualified by the gate |
| gate_sel | input | 1 | Gate source: 0 = gate_pin, 1 = cmp_in |
| gate_inv | input | 1 | 1 = the gate is active low |
| tick_in | input | 1 | Instruction-cycle enable pulse |
| ext_clk | input | 1 | External count clock, sampled |
| gate_pin | input | 1 | External gate pin, asynchronous |
| cmp_in | input | 1 | Comparator output used as a gate source |
| flag_clr | input | 1 | Pulse that clears the overflow flag |
| ie_local | input | 1 | Timer interrupt enable |
| ie_periph | input | 1 | Peripheral interrupt enable |
| ie_global | input | 1 | Global interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A stale or wrongly cleared prescale counter shows at the count bytes only when the next counter step is due. That can be up to eight events after the fault, so the bench holds the count under one divide setting and then checks the exact step. An error in the edge-detect or alignment flops shows as a count that moves one cycle early or late, or moves twice for one edge. The latency checks sample on each exact edge to catch this. A wrong flag priority appears on ovf_flag and irq on the first edge after a wrap that coincides with a clear.

// File: rtl/gtc_pkg.sv
// Shared definitions for the gated 16-bit timer.
// Assumes: the counter is made of two equal byte halves.
package gtc_pkg;
    localparam int CNT_W      = 16;
    localparam int BYTE_W     = CNT_W / 2;
    localparam int PSC_SEL_W  = 2;
    localparam int SYNC_DEPTH = 2;

    // Host byte select encoding.
    typedef enum logic {
        BYTE_LO = 1'b0,
        BYTE_HI = 1'b1
    } byte_sel_e;
endpackage

// File: rtl/gtc_sync.sv
// Brings the external count clock and the gate pin into the system clock
// domain. It detects rising edges of the count clock and can add one extra
// alignment flop to that edge pulse.
// Assumes: STAGES >= 2; both inputs may change at any time.
module gtc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic gate_pin,
    input  logic no_sync,
    output logic ext_edge,
    output logic gate_sync
);
    logic [STAGES-1:0] ext_sh;
    logic [STAGES-1:0] gate_sh;
    logic              ext_prev;
    logic              edge_raw;
    logic              edge_q;

    // Synchronizer chains; the flop at index 0 samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sh  <= '0;
            gate_sh <= '0;
        end else begin
            ext_sh  <= {ext_sh[STAGES-2:0], ext_clk};
            gate_sh <= {gate_sh[STAGES-2:0], gate_pin};
        end
    end

    assign edge_raw  = ext_sh[STAGES-1] & ~ext_prev;
    assign gate_sync = gate_sh[STAGES-1];

    // History flop for edge detection plus the optional alignment stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
            edge_q   <= 1'b0;
        end else begin
            ext_prev <= ext_sh[STAGES-1];
            edge_q   <= edge_raw;
        end
    end

    assign ext_edge = no_sync ? edge_raw : edge_q;

    // R5: an aligned edge pulse always follows a raw edge by one cycle
    // R5
    aligned_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_raw |=> edge_q);
endmodule

// File: rtl/gtc_prescale.sv
// Hidden prescale counter. It passes one event out of every 2^sel.
// It clears on a host write and holds when no event arrives.
// Assumes: clr has priority over evt.
module gtc_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] pre;
    logic [DIV_W-1:0] mask;

    // Low-bit mask for the selected ratio: 2^sel - 1.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign step = evt & ~clr & ((pre & mask) == mask);

    // Advance on each qualified event; clear on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clr) begin
            pre <= '0;
        end else if (evt) begin
            pre <= pre + 1'b1;
        end
    end

    // R4
    pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0));
    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(pre));
endmodule

// File: rtl/gtc_count.sv
// The 16-bit counter register with byte-wise host writes and the sticky
// overflow flag.
// Assumes: a write beats an increment in the same cycle, and setting the
// flag beats clearing it.
module gtc_count
    import gtc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    input  logic           wr_en,
    input  logic           wr_hi,
    input  logic [W/2-1:0] wr_data,
    input  logic           flag_clr,
    output logic [W-1:0]   cnt,
    output logic           ovf_flag
);
    localparam int H = W / 2;

    logic wrap;

    assign wrap = inc & ~wr_en & (&cnt);

    // Count register: a byte write wins, otherwise step when told to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            if (wr_hi) cnt[W-1:H] <= wr_data;
            else       cnt[H-1:0] <= wr_data;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Sticky overflow flag: setting it beats clearing it.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap)     ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    // R2
    wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (cnt[H-1:0] == $past(wr_data) &&
                               cnt[W-1:H] == $past(cnt[W-1:H])));
    // R3
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc) |=> $stable(cnt));
    // R8
    wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (ovf_flag && cnt == '0));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);
endmodule

// File: rtl/gated_timer16.sv
// Top level of the gated 16-bit timer/counter. It selects the count source,
// qualifies it with the run enable and the gate, feeds the prescaler and the
// counter, and forms the interrupt request.
// Assumes: one system clock; cmp_in is already synchronous to it.
module gated_timer16
    import gtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    cnt_lo,
    output logic [BYTE_W-1:0]    cnt_hi,
    input  logic                 run_en,
    input  logic                 src_ext,
    input  logic                 no_sync,
    input  logic [PSC_SEL_W-1:0] psc_sel,
    input  logic                 gate_en,
    input  logic                 gate_sel,
    input  logic                 gate_inv,
    input  logic                 tick_in,
    input  logic                 ext_clk,
    input  logic                 gate_pin,
    input  logic                 cmp_in,
    input  logic                 flag_clr,
    input  logic                 ie_local,
    input  logic                 ie_periph,
    input  logic                 ie_global,
    output logic                 ovf_flag,
    output logic                 irq
);
    logic             ext_edge;
    logic             gate_sync;
    logic             gate_act;
    logic             evt;
    logic             step;
    logic [CNT_W-1:0] cnt;
    byte_sel_e        wsel;

    assign wsel = byte_sel_e'(wr_sel);

    gtc_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .gate_pin  (gate_pin),
        .no_sync   (no_sync),
        .ext_edge  (ext_edge),
        .gate_sync (gate_sync)
    );

    // Gate qualification: pick the source, then apply the polarity.
    assign gate_act = (gate_sel ? cmp_in : gate_sync) ^ gate_inv;

    // One input event: running, the gate lets it through, and the source fires.
    assign evt = run_en & (~gate_en | gate_act) & (src_ext ? ext_edge : tick_in);

    gtc_prescale #(.SEL_W(PSC_SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (wr_en),
        .sel   (psc_sel),
        .step  (step)
    );

    gtc_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (step),
        .wr_en    (wr_en),
        .wr_hi    (wsel == BYTE_HI),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .ovf_flag (ovf_flag)
    );

    assign cnt_lo = cnt[BYTE_W-1:0];
    assign cnt_hi = cnt[CNT_W-1:BYTE_W];
    assign irq    = ovf_flag & ie_local & ie_periph & ie_global;

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en) |=> $stable(cnt));
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && ie_global));
    // R6
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && gate_sel && (cmp_in == gate_inv) && !wr_en) |=> $stable(cnt));
endmodule

// File: tb/gated_timer16_bench.sv
`timescale 1ns/1ps
module gated_timer16_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       run_en = 1, src_ext = 0, no_sync = 0;
    logic [1:0] psc_sel = 0;
    logic       gate_en = 0, gate_sel = 0, gate_inv = 0;
    logic       tick_in = 0, ext_clk = 0, gate_pin = 0, cmp_in = 0;
    logic       flag_clr = 0, ie_local = 0, ie_periph = 0, ie_global = 0;
    logic       ovf_flag, irq;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gated_timer16 u_gated_timer16 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .run_en(run_en), .src_ext(src_ext),
        .no_sync(no_sync), .psc_sel(psc_sel), .gate_en(gate_en), .gate_sel(gate_sel),
        .gate_inv(gate_inv), .tick_in(tick_in), .ext_clk(ext_clk), .gate_pin(gate_pin),
        .cmp_in(cmp_in), .flag_clr(flag_clr), .ie_local(ie_local), .ie_periph(ie_periph),
        .ie_global(ie_global), .ovf_flag(ovf_flag), .irq(irq)
    );

    // {psc_sel[1:0], events[7:0], expected count[15:0]}
    localparam logic [25:0] VEC [0:7] = '{
        {2'd0, 8'd5,  16'd5},
        {2'd1, 8'd5,  16'd2},
        {2'd1, 8'd6,  16'd3},
        {2'd2, 8'd7,  16'd1},
        {2'd2, 8'd8,  16'd2},
        {2'd3, 8'd15, 16'd1},
        {2'd3, 8'd16, 16'd2},
        {2'd0, 8'd0,  16'd0}
    };

    function automatic logic [15:0] cnt_now();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic load(input logic [15:0] v);
        wr_byte(1'b0, v[7:0]);
        wr_byte(1'b1, v[15:8]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1;
            @(negedge clk); tick_in = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        idle(3);
        // R1: state while in reset and just after release
        check("R1 count", {16'd0, cnt_now()}, 32'd0);
        check("R1 flag", {31'd0, ovf_flag}, 32'd0);
        rst_n = 1;
        idle(1);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R3: prescale table, timer mode
        for (int v = 0; v < 8; v++) begin
            psc_sel = VEC[v][25:24];
            load(16'h0000);
            ticks(int'(VEC[v][23:16]));
            check($sformatf("R3 vec%0d", v), {16'd0, cnt_now()}, {16'd0, VEC[v][15:0]});
        end

        // R2: independent byte writes
        load(16'h1234);
        check("R2 both", {16'd0, cnt_now()}, 32'h1234);
        wr_byte(1'b0, 8'hA5);
        check("R2 low only", {16'd0, cnt_now()}, 32'h12A5);
        // R2: write beats a same-cycle increment
        psc_sel = 0;
        @(negedge clk); tick_in = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h40;
        @(negedge clk); tick_in = 0; wr_en = 0;
        check("R2 write wins", {16'd0, cnt_now()}, 32'h1240);

        // R4: write clears the prescaler
        psc_sel = 3;
        load(16'h0000);
        ticks(3);
        wr_byte(1'b0, 8'h00);
        ticks(7);
        check("R4 cleared phase", {16'd0, cnt_now()}, 32'd0);
        ticks(1);
        check("R4 full period", {16'd0, cnt_now()}, 32'd1);

        // R7: stop holds count and prescaler phase
        psc_sel = 1;
        load(16'h0000);
        ticks(1);
        run_en = 0;
        ticks(3);
        check("R7 held", {16'd0, cnt_now()}, 32'd0);
        run_en = 1;
        ticks(1);
        check("R7 resumed phase", {16'd0, cnt_now()}, 32'd1);

        // R5: bypass latency
        psc_sel = 0; src_ext = 1; no_sync = 1;
        load(16'h0000);
        @(negedge clk); ext_clk = 1;
        idle(2);
        check("R5 bypass edge2", {16'd0, cnt_now()}, 32'd0);
        idle(1);
        check("R5 bypass edge3", {16'd0, cnt_now()}, 32'd1);
        idle(4);
        check("R5 single count", {16'd0, cnt_now()}, 32'd1);
        ext_clk = 0;
        // R5: aligned latency
        no_sync = 0;
        idle(4);
        load(16'h0000);
        @(negedge clk); ext_clk = 1;
        idle(3);
        check("R5 aligned edge3", {16'd0, cnt_now()}, 32'd0);
        idle(1);
        check("R5 aligned edge4", {16'd0, cnt_now()}, 32'd1);
        @(negedge clk); ext_clk = 0;
        idle(4);
        src_ext = 0;

        // R6: comparator gate, both polarities
        gate_en = 1; gate_sel = 1; gate_inv = 0; cmp_in = 0;
        load(16'h0000);
        ticks(3);
        check("R6 cmp low blocks", {16'd0, cnt_now()}, 32'd0);
        cmp_in = 1;
        ticks(3);
        check("R6 cmp high counts", {16'd0, cnt_now()}, 32'd3);
        gate_inv = 1;
        ticks(2);
        check("R6 inverted blocks", {16'd0, cnt_now()}, 32'd3);
        // R6: gate pin source
        gate_sel = 0; gate_inv = 0; gate_pin = 0;
        idle(3);
        ticks(2);
        check("R6 pin low blocks", {16'd0, cnt_now()}, 32'd3);
        gate_pin = 1;
        idle(3);
        ticks(2);
        check("R6 pin high counts", {16'd0, cnt_now()}, 32'd5);
        gate_en = 0; gate_pin = 0;
        ticks(1);
        check("R6 gate ignored", {16'd0, cnt_now()}, 32'd6);

        // R8: wrap sets the flag on the same edge
        load(16'hFFFE);
        ticks(1);
        check("R8 no early flag", {15'd0, ovf_flag, cnt_now()}, 32'h0FFFF);
        ticks(1);
        check("R8 wrap flag", {15'd0, ovf_flag, cnt_now()}, 32'h10000);
        ticks(2);
        check("R8 sticky", {31'd0, ovf_flag}, 32'd1);

        // R9: irq needs all enables
        ie_local = 1; ie_periph = 1; ie_global = 1;
        idle(1);
        check("R9 all set", {31'd0, irq}, 32'd1);
        ie_global = 0; idle(1);
        check("R9 global off", {31'd0, irq}, 32'd0);
        ie_global = 1; ie_periph = 0; idle(1);
        check("R9 periph off", {31'd0, irq}, 32'd0);
        ie_periph = 1; ie_local = 0; idle(1);
        check("R9 local off", {31'd0, irq}, 32'd0);
        ie_local = 1;

        // R8: set beats a same-cycle clear
        load(16'hFFFF);
        @(negedge clk); tick_in = 1; flag_clr = 1;
        @(negedge clk); tick_in = 0; flag_clr = 0;
        check("R8 set beats clear", {15'd0, ovf_flag, cnt_now()}, 32'h10000);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        check("R8 cleared", {30'd0, ovf_flag, irq}, 32'd0);

        finish_run();
    end
endmodule